// File: doc/BRIEF.md
# UART Channel Interrupt Enable and Masking Unit

This block sits beside one channel of a multi-channel UART and decides which channel events become interrupts. The host writes and reads an 8-bit enable register. The unit takes single-cycle event pulses from the receiver, the transmitter and the modem-control logic. It also compares every received character against four programmable special-character slots. An event whose enable is set latches a sticky pending flag. The highest-priority pending flag is reported as a 3-bit code. A single interrupt line is asserted while anything is pending, unless an external global mask holds it low.

The same enable bits are read differently in three framing and compatibility modes: 9-bit framing, enhanced mode and legacy (non-enhanced) mode. In 9-bit framing, bit 2 also covers received characters that carry the address (ninth) bit, and bit 5 enables matching against all four slots. In enhanced mode with 8-bit framing, bit 5 enables flow-control character detection. In legacy mode, bit 5 becomes a second sleep bit. The RTS and CTS change enables apply only in enhanced mode and are forced on elsewhere.

A small state machine with the states ST_RUN and ST_SLEEP drives a sleep request that stops the channel clock. It makes the ENTER transition (ST_RUN to ST_SLEEP) when sleep is enabled, nothing is pending and the receiver is idle. It makes the WAKE transition (ST_SLEEP to ST_RUN) when sleep is disabled, a flag is pending or the receiver becomes active.

Top module: `uart_irq_mask_unit`

## Requirements
- R1: After reset the enable register, all six pending flags and all special-character slots are 0. `irq_code` is 0, and `irq_out` and `sleep_req` are low.
- R2: A cycle with `ier_wr` high loads `ier_wdata` into the enable register at that clock edge. `ier_rdata` always shows the register.
- R3: Enable bit 0 gates the receive-data event (code 2), bit 1 gates the transmit-empty event (code 3) and bit 3 gates the modem-status event (code 4). An event whose enable is 0 never sets its flag.
- R4: Enable bit 2 gates the line-status event (code 1). With `nine_bit_mode`=1, a valid received character with `rx_char[8]`=1 also raises code 1 when bit 2 is set. With `nine_bit_mode`=0, the ninth bit raises nothing.
- R5: With `nine_bit_mode`=1 and enable bit 5 set, a valid character whose `rx_char[7:0]` equals any of the four slots raises code 5. With bit 5 clear, no match raises anything.
- R6: With `nine_bit_mode`=0 and `enh_cfg[4]`=1 (enhanced mode), bit 5 enables detection against only two slots. Slot 0 (the XOFF character) counts when `enh_cfg[3:0]` is nonzero. Slot 1 (the second XOFF character) counts when `enh_cfg[5]`=1. Slots 2 and 3 are ignored. In legacy mode (`enh_cfg[4]`=0, `nine_bit_mode`=0) no character match raises anything.
- R7: RTS and CTS change events raise code 6. In enhanced mode they are gated by enable bits 6 and 7 respectively. Outside enhanced mode they always raise code 6, whatever those bits hold.
- R8: `irq_code` reports the lowest-numbered pending level (1 is the highest priority, 6 the lowest), or 0 when none is pending.
- R9: A pending flag stays set until a one-cycle strobe on its bit of `irq_clr`, where bit k clears level k+1. A set and a clear in the same cycle leave the flag set.
- R10: `irq_out` is high exactly when some flag is pending and `irq_gmask` is 0. Only the enable register and `irq_gmask` can gate it.
- R11: Sleep is enabled by bit 4, or by bit 5 in legacy mode. ENTER takes place one edge after sleep is enabled while no flag is pending and `rx_idle` is 1. WAKE takes place on the edge after a flag becomes pending, after `rx_idle` falls, or after sleep is disabled. `sleep_req` is high in ST_SLEEP only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read data |
| nine_bit_mode | input | 1 | 9-bit framing selected |
| enh_cfg | input | 6 | [3:0] in-band flow control setting, [4] enhanced mode, [5] second XOFF enable |
| spc_wr | input | 1 | Special-character slot write strobe |
| spc_idx | input | 2 | Slot index for the write |
| spc_wdata | input | 8 | Slot write data |
| rx_char_valid | input | 1 | A received character is presented this cycle |
| rx_char | input | 9 | Received character, bit 8 is the address bit |
| rx_idle | input | 1 | Receiver has no activity |
| ev_rx_status | input | 1 | Line-status event pulse |
| ev_rx_data | input | 1 | Receive-data-available event pulse |
| ev_tx_empty | input | 1 | Transmitter-empty event pulse |
| ev_modem | input | 1 | Modem-status change pulse |
| ev_rts | input | 1 | RTS change pulse |
| ev_cts | input | 1 | CTS change pulse |
| irq_clr | input | 6 | Per-level clear strobes, bit k clears level k+1 |
| irq_gmask | input | 1 | Global mask, 1 holds irq_out low |
| irq_code | output | 3 | Highest pending level, 0 when none |
| irq_out | output | 1 | Interrupt line |
| sleep_req | output | 1 | Request to stop the channel clock |

## Verification
A vector table drives each event source alone in each mode, with its enable bit both set and cleared. This separates the enable gating from the mode decoding. Characters that match a slot are sent in all three modes and with different flow-control settings, which shows whether slot qualification depends on the mode. Simultaneous events of different levels expose the priority order. Directed sequences cover the case where a set and a clear land on the same flag, the global mask, and the ENTER and WAKE transitions from the three wake causes.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int N_LVL  = 6;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        MD_LEGACY   = 2'd0,
        MD_ENHANCED = 2'd1,
        MD_NINEBIT  = 2'd2
    } frame_mode_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } slp_state_e;

    function automatic frame_mode_e decode_mode(input logic nine, input logic enh);
        if (nine)
            return MD_NINEBIT;
        else if (enh)
            return MD_ENHANCED;
        else
            return MD_LEGACY;
    endfunction
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
    import uirq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  frame_mode_e      mode,
    output logic [REG_W-1:0] rdata,
    output logic             en_lsr,
    output logic             en_rxd,
    output logic             en_txe,
    output logic             en_msr,
    output logic             en_spc,
    output logic             en_rts,
    output logic             en_cts,
    output logic             sleep_en
);
    logic [REG_W-1:0] ier_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ier_q <= '0;
        else if (wr)
            ier_q <= wdata;
    end

    assign rdata = ier_q;

    always_comb begin
        en_rxd   = ier_q[0];
        en_txe   = ier_q[1];
        en_lsr   = ier_q[2];
        en_msr   = ier_q[3];
        en_spc   = 1'b0;
        en_rts   = 1'b1;
        en_cts   = 1'b1;
        sleep_en = ier_q[4];
        unique case (mode)
            MD_NINEBIT: begin
                en_spc = ier_q[5];
            end
            MD_ENHANCED: begin
                en_spc = ier_q[5];
                en_rts = ier_q[6];
                en_cts = ier_q[7];
            end
            MD_LEGACY: begin
                sleep_en = ier_q[4] | ier_q[5];
            end
            default: begin
                en_spc = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/uirq_spchar_match.sv
module uirq_spchar_match
    import uirq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int N_SPC = 4,
    localparam int IDX_W = $clog2(N_SPC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  frame_mode_e      mode,
    input  logic             inband_on,
    input  logic             xoff2_on,
    input  logic             chr_valid,
    input  logic [DW-1:0]    chr,
    output logic             hit
);
    logic [N_SPC-1:0] slot_eq;
    logic [N_SPC-1:0] slot_live;

    for (genvar g = 0; g < N_SPC; g++) begin : g_slot
        logic [DW-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr && (idx == IDX_W'(g)))
                slot_q <= wdata;
        end

        assign slot_eq[g] = (slot_q == chr);

        if (g == 0) begin : g_xoff1
            assign slot_live[g] = (mode == MD_NINEBIT) ||
                                  ((mode == MD_ENHANCED) && inband_on);
        end else if (g == 1) begin : g_xoff2
            assign slot_live[g] = (mode == MD_NINEBIT) ||
                                  ((mode == MD_ENHANCED) && xoff2_on);
        end else begin : g_nine_only
            assign slot_live[g] = (mode == MD_NINEBIT);
        end
    end

    assign hit = chr_valid && |(slot_eq & slot_live);
endmodule

// File: rtl/uirq_pending.sv
module uirq_pending
    import uirq_pkg::*;
#(
    parameter int NL = N_LVL,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] set_req,
    input  logic [NL-1:0] clr_req,
    output logic [NL-1:0] pend,
    output logic [CW-1:0] code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= '0;
        else
            pend <= (pend & ~clr_req) | set_req;
    end

    always_comb begin
        code = '0;
        for (int k = NL - 1; k >= 0; k--) begin
            if (pend[k])
                code = CW'(k + 1);
        end
    end
endmodule

// File: rtl/uirq_sleep_fsm.sv
module uirq_sleep_fsm
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_en,
    input  logic any_pend,
    input  logic rx_idle,
    output logic sleep_req
);
    slp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_en && !any_pend && rx_idle)
                    state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (!sleep_en || any_pend || !rx_idle)
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        sleep_req = (state_q == ST_SLEEP);
    end
endmodule

// File: rtl/uart_irq_mask_unit.sv
module uart_irq_mask_unit
    import uirq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int N_SPC = 4,
    localparam int IDX_W = $clog2(N_SPC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic [7:0]        ier_wdata,
    output logic [7:0]        ier_rdata,
    input  logic              nine_bit_mode,
    input  logic [5:0]        enh_cfg,
    input  logic              spc_wr,
    input  logic [IDX_W-1:0]  spc_idx,
    input  logic [DW-1:0]     spc_wdata,
    input  logic              rx_char_valid,
    input  logic [DW:0]       rx_char,
    input  logic              rx_idle,
    input  logic              ev_rx_status,
    input  logic              ev_rx_data,
    input  logic              ev_tx_empty,
    input  logic              ev_modem,
    input  logic              ev_rts,
    input  logic              ev_cts,
    input  logic [N_LVL-1:0]  irq_clr,
    input  logic              irq_gmask,
    output logic [CODE_W-1:0] irq_code,
    output logic              irq_out,
    output logic              sleep_req
);
    frame_mode_e      mode;
    logic             en_lsr, en_rxd, en_txe, en_msr, en_spc, en_rts, en_cts, sleep_en;
    logic             spc_hit;
    logic             addr_hit;
    logic [N_LVL-1:0] set_req;
    logic [N_LVL-1:0] pend;

    assign mode = decode_mode(nine_bit_mode, enh_cfg[4]);

    uirq_enable_reg #(.REG_W(8)) u_ier (
        .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata), .mode(mode),
        .rdata(ier_rdata), .en_lsr(en_lsr), .en_rxd(en_rxd), .en_txe(en_txe),
        .en_msr(en_msr), .en_spc(en_spc), .en_rts(en_rts), .en_cts(en_cts),
        .sleep_en(sleep_en)
    );

    uirq_spchar_match #(.DW(DW), .N_SPC(N_SPC)) u_match (
        .clk(clk), .rst_n(rst_n), .wr(spc_wr), .idx(spc_idx), .wdata(spc_wdata),
        .mode(mode), .inband_on(|enh_cfg[3:0]), .xoff2_on(enh_cfg[5]),
        .chr_valid(rx_char_valid), .chr(rx_char[DW-1:0]), .hit(spc_hit)
    );

    assign addr_hit = (mode == MD_NINEBIT) && rx_char_valid && rx_char[DW];

    always_comb begin
        set_req[0] = en_lsr && (ev_rx_status || addr_hit);
        set_req[1] = en_rxd && ev_rx_data;
        set_req[2] = en_txe && ev_tx_empty;
        set_req[3] = en_msr && ev_modem;
        set_req[4] = en_spc && spc_hit;
        set_req[5] = (en_rts && ev_rts) || (en_cts && ev_cts);
    end

    uirq_pending #(.NL(N_LVL), .CW(CODE_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(irq_clr),
        .pend(pend), .code(irq_code)
    );

    assign irq_out = (|pend) && !irq_gmask;

    uirq_sleep_fsm u_sleep (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .any_pend(|pend),
        .rx_idle(rx_idle), .sleep_req(sleep_req)
    );
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr,
    input logic [7:0] ier_wdata,
    input logic [7:0] ier_rdata,
    input logic       rx_idle,
    input logic       irq_gmask,
    input logic [2:0] irq_code,
    input logic       irq_out,
    input logic       sleep_req
);
    // R2: a write is visible on the next cycle
    assert_ier_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier_rdata == $past(ier_wdata)));

    // R8: the code stays within the six levels
    assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_code <= 3'd6);

    // R10: the line follows the pending code and the global mask
    assert_line_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == ((irq_code != 3'd0) && !irq_gmask));

    // R11: entering sleep requires nothing pending and an idle receiver
    assert_enter_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |-> $past(irq_code == 3'd0 && rx_idle));

    // R11: receive activity ends sleep on the next edge
    assert_wake_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !rx_idle) |=> !sleep_req);

    // R11: a pending level ends sleep on the next edge
    assert_wake_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && irq_code != 3'd0) |=> !sleep_req);
endmodule

bind uart_irq_mask_unit uirq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .ier_rdata(ier_rdata), .rx_idle(rx_idle), .irq_gmask(irq_gmask),
    .irq_code(irq_code), .irq_out(irq_out), .sleep_req(sleep_req)
);

// File: tb/tb_uart_irq_mask_unit.sv
module tb_uart_irq_mask_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [7:0] ier_rdata;
    logic       nine_bit_mode = 1'b0;
    logic [5:0] enh_cfg = '0;
    logic       spc_wr = 1'b0;
    logic [1:0] spc_idx = '0;
    logic [7:0] spc_wdata = '0;
    logic       rx_char_valid = 1'b0;
    logic [8:0] rx_char = '0;
    logic       rx_idle = 1'b1;
    logic [5:0] ev = '0;
    logic [5:0] irq_clr = '0;
    logic       irq_gmask = 1'b0;
    logic [2:0] irq_code;
    logic       irq_out;
    logic       sleep_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_irq_mask_unit dut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ier_rdata(ier_rdata), .nine_bit_mode(nine_bit_mode), .enh_cfg(enh_cfg),
        .spc_wr(spc_wr), .spc_idx(spc_idx), .spc_wdata(spc_wdata),
        .rx_char_valid(rx_char_valid), .rx_char(rx_char), .rx_idle(rx_idle),
        .ev_rx_status(ev[5]), .ev_rx_data(ev[4]), .ev_tx_empty(ev[3]),
        .ev_modem(ev[2]), .ev_rts(ev[1]), .ev_cts(ev[0]),
        .irq_clr(irq_clr), .irq_gmask(irq_gmask),
        .irq_code(irq_code), .irq_out(irq_out), .sleep_req(sleep_req)
    );

    // ev bits: [5] line status, [4] rx data, [3] tx empty, [2] modem, [1] rts, [0] cts
    typedef struct packed {
        logic       nine;
        logic [5:0] enh;
        logic [7:0] ier;
        logic [5:0] ev;
        logic       cv;
        logic [8:0] ch;
        logic [2:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 6'h00, 8'h01, 6'b010000, 1'b0, 9'h000, 3'd2}, // R3 rx data on
        '{1'b0, 6'h00, 8'h00, 6'b010000, 1'b0, 9'h000, 3'd0}, // R3 rx data off
        '{1'b0, 6'h00, 8'h02, 6'b001000, 1'b0, 9'h000, 3'd3}, // R3 tx empty
        '{1'b0, 6'h00, 8'h08, 6'b000100, 1'b0, 9'h000, 3'd4}, // R3 modem
        '{1'b0, 6'h00, 8'h0F, 6'b011100, 1'b0, 9'h000, 3'd2}, // R8 priority
        '{1'b1, 6'h00, 8'h04, 6'b000000, 1'b1, 9'h100, 3'd1}, // R4 address bit
        '{1'b0, 6'h00, 8'h04, 6'b000000, 1'b1, 9'h100, 3'd0}, // R4 not in 8-bit
        '{1'b1, 6'h00, 8'h20, 6'b000000, 1'b1, 9'h0AA, 3'd5}, // R5 slot 3 hit
        '{1'b1, 6'h00, 8'h00, 6'b000000, 1'b1, 9'h0AA, 3'd0}, // R5 disabled
        '{1'b0, 6'h11, 8'h20, 6'b000000, 1'b1, 9'h013, 3'd5}, // R6 xoff
        '{1'b0, 6'h10, 8'h20, 6'b000000, 1'b1, 9'h013, 3'd0}, // R6 no inband
        '{1'b0, 6'h30, 8'h20, 6'b000000, 1'b1, 9'h093, 3'd5}, // R6 xoff2
        '{1'b0, 6'h30, 8'h20, 6'b000000, 1'b1, 9'h055, 3'd0}, // R6 slot 2 ignored
        '{1'b0, 6'h0F, 8'h20, 6'b000000, 1'b1, 9'h013, 3'd0}, // R6 legacy no match
        '{1'b0, 6'h10, 8'h00, 6'b000010, 1'b0, 9'h000, 3'd0}, // R7 rts gated
        '{1'b0, 6'h10, 8'h40, 6'b000010, 1'b0, 9'h000, 3'd6}, // R7 rts on
        '{1'b0, 6'h10, 8'h80, 6'b000001, 1'b0, 9'h000, 3'd6}, // R7 cts on
        '{1'b0, 6'h00, 8'h00, 6'b000001, 1'b0, 9'h000, 3'd6}, // R7 legacy forced
        '{1'b1, 6'h00, 8'h25, 6'b010000, 1'b1, 9'h055, 3'd2}  // R8 level 2 over 5
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ier(input logic [7:0] v);
        ier_wr = 1'b1;
        ier_wdata = v;
        tick();
        ier_wr = 1'b0;
    endtask

    task automatic clear_all();
        irq_clr = 6'h3F;
        tick();
        irq_clr = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        // R1 reset state
        check("R1 code", int'(irq_code), 0);
        check("R1 irq_out", int'(irq_out), 0);
        check("R1 sleep", int'(sleep_req), 0);
        check("R1 ier", int'(ier_rdata), 0);
        rst_n = 1'b1;
        tick();

        // R2 write and read back
        write_ier(8'hA5);
        check("R2 readback", int'(ier_rdata), 8'hA5);
        write_ier(8'h00);

        // program slots: 0=13, 1=93, 2=55, 3=AA
        for (int s = 0; s < 4; s++) begin
            spc_wr = 1'b1;
            spc_idx = 2'(s);
            spc_wdata = (s == 0) ? 8'h13 : (s == 1) ? 8'h93 : (s == 2) ? 8'h55 : 8'hAA;
            tick();
        end
        spc_wr = 1'b0;

        for (int i = 0; i < NV; i++) begin
            clear_all();
            nine_bit_mode = TBL[i].nine;
            enh_cfg = TBL[i].enh;
            write_ier(TBL[i].ier);
            ev = TBL[i].ev;
            rx_char_valid = TBL[i].cv;
            rx_char = TBL[i].ch;
            tick();
            ev = '0;
            rx_char_valid = 1'b0;
            check($sformatf("R3-vector %0d code", i), int'(irq_code), int'(TBL[i].exp));
            check($sformatf("R10 vector %0d line", i), int'(irq_out), int'(TBL[i].exp != 3'd0));
        end

        // R9 sticky and per-level clear
        clear_all();
        nine_bit_mode = 1'b0;
        enh_cfg = 6'h00;
        write_ier(8'h03);
        ev = 6'b011000;
        tick();
        ev = '0;
        tick();
        check("R9 sticky", int'(irq_code), 2);
        irq_clr = 6'b000010;
        tick();
        irq_clr = '0;
        check("R9 clear level 2", int'(irq_code), 3);
        ev = 6'b010000;
        irq_clr = 6'b000010;
        tick();
        ev = '0;
        irq_clr = '0;
        check("R9 set wins", int'(irq_code), 2);

        // R10 global mask
        irq_gmask = 1'b1;
        tick();
        check("R10 masked", int'(irq_out), 0);
        irq_gmask = 1'b0;
        tick();
        check("R10 unmasked", int'(irq_out), 1);

        // R11 sleep entry via bit 4
        clear_all();
        write_ier(8'h10);
        tick();
        check("R11 enter", int'(sleep_req), 1);
        rx_idle = 1'b0;
        tick();
        check("R11 wake rx", int'(sleep_req), 0);
        rx_idle = 1'b1;
        tick();
        tick();
        check("R11 re-enter", int'(sleep_req), 1);
        write_ier(8'h00);
        tick();
        check("R11 wake disable", int'(sleep_req), 0);

        // R11 alternate sleep bit in legacy mode only
        write_ier(8'h20);
        tick();
        check("R11 alt sleep legacy", int'(sleep_req), 1);
        enh_cfg = 6'h10;
        tick();
        tick();
        check("R11 alt sleep enhanced", int'(sleep_req), 0);
        enh_cfg = 6'h00;

        // R11 wake on pending event
        write_ier(8'h11);
        tick();
        check("R11 sleeping", int'(sleep_req), 1);
        ev = 6'b010000;
        tick();
        ev = '0;
        check("R11 still asleep", int'(sleep_req), 1);
        tick();
        check("R11 wake pending", int'(sleep_req), 0);

        // R1 reset clears pending
        rst_n = 1'b0;
        tick();
        check("R1 reset clears", int'(irq_code), 0);
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule